// File: doc/BRIEF.md
# Line Freshness Tag Table

This block keeps one short freshness tag for every protected data line, held on chip so that an outside party cannot rewrite it. The tag is a fixed slice of the line's latest integrity signature. Whenever a dirty line is written back to memory, the caller presents the line address together with the newly computed signature, and the table stores the slice for that address. Whenever a line is fetched from memory, the caller presents the address together with the signature recomputed over the fetched contents. The table compares that slice with the stored tag and reports whether the line is fresh, a replay of an older copy, or a line for which no tag has been recorded yet.

No counter is involved, so nothing can wrap around and force the whole memory to be re-keyed. Freshness holds up to the collision odds of the chosen tag width, and that width and its bit offset inside the signature are both parameters. A clear input invalidates every entry at once, for example when a new process image is loaded.

Top module: `fresh_tag_table`

## Requirements
- R1: After reset `rsp_valid` is 0, `rsp_status` is 2'b00, and every entry is invalid, so any fetch reports no-entry.
- R2: A write-back stores bits [TAG_LSB+TAG_W-1:TAG_LSB] of `wb_sig` as the tag of line `wb_addr`. A later fetch of that line whose signature carries the same slice reports fresh (2'b01).
- R3: A fetch of a valid line whose signature slice differs from the stored tag reports replay (2'b10).
- R4: Signature bits outside the tag slice have no effect on the result.
- R5: A fetch of a line that has never been written since reset or since the last clear reports no-entry (2'b11).
- R6: `rsp_valid` is 1 in exactly the cycle after a cycle with `fill_en` high and is 0 otherwise. `rsp_status` is 2'b00 whenever `rsp_valid` is 0.
- R7: A write-back and a fetch of the same address in the same cycle are resolved write-first: the fetch is compared against the new tag.
- R8: A later write-back to a line replaces its tag, so a fetch that carries the earlier tag reports replay.
- R9: `clr_all` invalidates all entries. A write-back in the same cycle is dropped, and a fetch in the same cycle reports no-entry.
- R10: A write-back changes only the entry of its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_all | input | 1 | Invalidate every entry |
| wb_en | input | 1 | Write-back request |
| wb_addr | input | ADDR_W | Line address of the write-back |
| wb_sig | input | SIG_W | New signature of the written line |
| fill_en | input | 1 | Fetch check request |
| fill_addr | input | ADDR_W | Line address of the fetch |
| fill_sig | input | SIG_W | Signature recomputed over the fetched line |
| rsp_valid | output | 1 | Result present, one cycle after `fill_en` |
| rsp_status | output | 2 | 00 idle, 01 fresh, 10 replay, 11 no-entry |

## Verification
The assertions watch the response timing on every cycle: one result per fetch, one cycle later, and an idle status code in between. They also cover the outcome of a write-back and a fetch that hit the same address in the same cycle, and of a fetch that coincides with a clear. Whether a tag survives across many cycles, gets replaced by a later write-back, stays confined to its own line, and ignores signature bits outside the slice can only be shown by the bench's write-then-fetch scenarios.

// File: rtl/fresh_tag_pkg.sv
`timescale 1ns/1ps
// Shared types for the freshness tag table.
package fresh_tag_pkg;

    // Result code of one fetch check.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_FRESH   = 2'b01,
        ST_REPLAY  = 2'b10,
        ST_NOENTRY = 2'b11
    } fresh_status_e;

endpackage

// File: rtl/tag_slicer.sv
`timescale 1ns/1ps
// tag_slicer: picks the freshness tag out of a full line signature.
// Assumes TAG_LSB + TAG_W <= SIG_W.
module tag_slicer #(
    parameter int SIG_W   = 160,
    parameter int TAG_W   = 32,
    parameter int TAG_LSB = 0
) (
    input  logic [SIG_W-1:0] sig,
    output logic [TAG_W-1:0] tag
);

    generate
        if (TAG_W == SIG_W) begin : g_full
            // Tag is the whole signature.
            assign tag = sig;
        end else begin : g_slice
            // Tag is a contiguous slice of the signature.
            assign tag = sig[TAG_LSB +: TAG_W];
        end
    endgenerate

endmodule

// File: rtl/tag_store.sv
`timescale 1ns/1ps
// tag_store: one tag and one valid flag per line.
// Reads are combinational with write-first bypass for a write to the
// same address in the same cycle. Clear wins over a simultaneous write.
// Tag storage is not reset; only valid flags are.
module tag_store #(
    parameter int ADDR_W = 6,
    parameter int TAG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid
);

    localparam int LINES = 2 ** ADDR_W;

    logic [TAG_W-1:0] tag_mem [LINES];
    logic [LINES-1:0] vld_q;
    logic             wr_live;

    assign wr_live = wr_en && !clr_all;

    // Tag array write port.
    always_ff @(posedge clk) begin
        if (wr_live) begin
            tag_mem[wr_addr] <= wr_tag;
        end
    end

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_vld
            // Per-line valid flag: cleared by reset or clear, set on write.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_all) begin
                    vld_q[i] <= 1'b0;
                end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                    vld_q[i] <= 1'b1;
                end
            end
        end
    endgenerate

    // Read port with write-first bypass; clear reads as empty.
    always_comb begin
        if (clr_all) begin
            rd_tag   = tag_mem[rd_addr];
            rd_valid = 1'b0;
        end else if (wr_live && wr_addr == rd_addr) begin
            rd_tag   = wr_tag;
            rd_valid = 1'b1;
        end else begin
            rd_tag   = tag_mem[rd_addr];
            rd_valid = vld_q[rd_addr];
        end
    end

endmodule

// File: rtl/tag_compare.sv
`timescale 1ns/1ps
// tag_compare: registers the verdict of one fetch check.
// Assumes entry_valid and stored_tag already reflect write-first order.
module tag_compare
    import fresh_tag_pkg::*;
#(
    parameter int TAG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lookup_en,
    input  logic             entry_valid,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] fetched_tag,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status
);

    fresh_status_e verdict;

    // Classify the lookup.
    always_comb begin
        if (!entry_valid) begin
            verdict = ST_NOENTRY;
        end else if (stored_tag == fetched_tag) begin
            verdict = ST_FRESH;
        end else begin
            verdict = ST_REPLAY;
        end
    end

    // Response register: one cycle after the lookup, idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= ST_IDLE;
        end else begin
            rsp_valid  <= lookup_en;
            rsp_status <= lookup_en ? verdict : ST_IDLE;
        end
    end

endmodule

// File: rtl/fresh_tag_table.sv
`timescale 1ns/1ps
// fresh_tag_table: on-chip freshness tags, one per data line.
// A write-back stores a slice of the new signature; a fetch compares the
// slice of the recomputed signature with the stored one, one cycle later.
// Assumes the caller computes signatures over line contents and address.
module fresh_tag_table #(
    parameter int ADDR_W  = 6,
    parameter int SIG_W   = 160,
    parameter int TAG_W   = 32,
    parameter int TAG_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [SIG_W-1:0]  wb_sig,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [SIG_W-1:0]  fill_sig,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status
);

    logic [TAG_W-1:0] wb_tag;
    logic [TAG_W-1:0] fill_tag;
    logic [TAG_W-1:0] stored_tag;
    logic             stored_valid;

    tag_slicer #(.SIG_W(SIG_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB)) u_wb_slice (
        .sig (wb_sig),
        .tag (wb_tag)
    );

    tag_slicer #(.SIG_W(SIG_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB)) u_fill_slice (
        .sig (fill_sig),
        .tag (fill_tag)
    );

    tag_store #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (clr_all),
        .wr_en    (wb_en),
        .wr_addr  (wb_addr),
        .wr_tag   (wb_tag),
        .rd_addr  (fill_addr),
        .rd_tag   (stored_tag),
        .rd_valid (stored_valid)
    );

    tag_compare #(.TAG_W(TAG_W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .lookup_en   (fill_en),
        .entry_valid (stored_valid),
        .stored_tag  (stored_tag),
        .fetched_tag (fill_tag),
        .rsp_valid   (rsp_valid),
        .rsp_status  (rsp_status)
    );

endmodule

// File: rtl/fresh_tag_table_chk.sv
`timescale 1ns/1ps
// fresh_tag_table_chk: protocol and ordering properties of the table.
module fresh_tag_table_chk #(
    parameter int ADDR_W  = 6,
    parameter int SIG_W   = 160,
    parameter int TAG_W   = 32,
    parameter int TAG_LSB = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_all,
    input logic              wb_en,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [SIG_W-1:0]  wb_sig,
    input logic              fill_en,
    input logic [ADDR_W-1:0] fill_addr,
    input logic [SIG_W-1:0]  fill_sig,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status
);

    logic same_line;
    logic same_tag;

    assign same_line = fill_en && wb_en && !clr_all && (fill_addr == wb_addr);
    assign same_tag  = wb_sig[TAG_LSB +: TAG_W] == fill_sig[TAG_LSB +: TAG_W];

    // R6
    rsp_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> rsp_valid);

    // R6
    no_rsp_without_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> !rsp_valid);

    // R6
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_status == 2'b00);

    // R7
    bypass_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (same_line && same_tag) |=> rsp_status == 2'b01);

    // R7
    bypass_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (same_line && !same_tag) |=> rsp_status == 2'b10);

    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && fill_en) |=> rsp_status == 2'b11);

endmodule

bind fresh_tag_table fresh_tag_table_chk #(
    .ADDR_W(ADDR_W), .SIG_W(SIG_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (clr_all),
    .wb_en      (wb_en),
    .wb_addr    (wb_addr),
    .wb_sig     (wb_sig),
    .fill_en    (fill_en),
    .fill_addr  (fill_addr),
    .fill_sig   (fill_sig),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status)
);

// File: tb/fresh_tag_table_tb_top.sv
`timescale 1ns/1ps
// Directed bench for fresh_tag_table: one task per scenario.
module fresh_tag_table_tb_top;

    localparam int ADDR_W  = 6;
    localparam int SIG_W   = 160;
    localparam int TAG_W   = 32;
    localparam int TAG_LSB = 0;

    localparam logic [1:0] S_IDLE  = 2'b00;
    localparam logic [1:0] S_FRESH = 2'b01;
    localparam logic [1:0] S_RPLY  = 2'b10;
    localparam logic [1:0] S_NONE  = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr_all = 1'b0;
    logic              wb_en = 1'b0;
    logic [ADDR_W-1:0] wb_addr = '0;
    logic [SIG_W-1:0]  wb_sig = '0;
    logic              fill_en = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [SIG_W-1:0]  fill_sig = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_status;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    fresh_tag_table #(
        .ADDR_W(ADDR_W), .SIG_W(SIG_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_sig(wb_sig),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_sig(fill_sig),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status)
    );

    function automatic logic [SIG_W-1:0] mk_sig(input logic [TAG_W-1:0] tag,
                                                input logic [31:0] salt);
        logic [SIG_W-1:0] s;
        s = {5{salt ^ 32'h5A5A_C3C3}};
        s[TAG_LSB +: TAG_W] = tag;
        return s;
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Drive one cycle of inputs (called at a falling edge), then idle them.
    task automatic step(input logic fe, input logic [ADDR_W-1:0] fa,
                        input logic [SIG_W-1:0] fs, input logic we,
                        input logic [ADDR_W-1:0] wa, input logic [SIG_W-1:0] ws,
                        input logic clr);
        fill_en = fe; fill_addr = fa; fill_sig = fs;
        wb_en = we; wb_addr = wa; wb_sig = ws; clr_all = clr;
        @(negedge clk);
        fill_en = 1'b0; wb_en = 1'b0; clr_all = 1'b0;
    endtask

    task automatic wb(input logic [ADDR_W-1:0] a, input logic [SIG_W-1:0] s);
        step(1'b0, '0, '0, 1'b1, a, s, 1'b0);
    endtask

    task automatic fetch(input string req, input logic [ADDR_W-1:0] a,
                         input logic [SIG_W-1:0] s, input logic [1:0] exp_st);
        step(1'b1, a, s, 1'b0, '0, '0, 1'b0);
        check(req, rsp_valid, 1);
        check(req, rsp_status, exp_st);
    endtask

    task automatic t_reset();
        check("R1 valid", rsp_valid, 0);
        check("R1 status", rsp_status, S_IDLE);
        fetch("R1 line0", 6'd0, mk_sig(32'h1, 1), S_NONE);
        fetch("R5 line63", 6'd63, mk_sig(32'h0, 2), S_NONE);
    endtask

    task automatic t_store_and_match();
        wb(6'd5, mk_sig(32'hA1A1_0001, 7));
        fetch("R2 match", 6'd5, mk_sig(32'hA1A1_0001, 7), S_FRESH);
        fetch("R4 upper bits differ", 6'd5, mk_sig(32'hA1A1_0001, 99), S_FRESH);
        fetch("R3 stale slice", 6'd5, mk_sig(32'hA1A1_0002, 7), S_RPLY);
    endtask

    task automatic t_latency();
        fill_en = 1'b1; fill_addr = 6'd5; fill_sig = mk_sig(32'hA1A1_0001, 7);
        @(negedge clk);
        fill_en = 1'b0;
        check("R6 one-cycle valid", rsp_valid, 1);
        @(negedge clk);
        check("R6 drops after", rsp_valid, 0);
        check("R6 idle code", rsp_status, S_IDLE);
    endtask

    task automatic t_replace();
        wb(6'd5, mk_sig(32'hC0DE_0003, 3));
        fetch("R8 old tag", 6'd5, mk_sig(32'hA1A1_0001, 7), S_RPLY);
        fetch("R8 new tag", 6'd5, mk_sig(32'hC0DE_0003, 3), S_FRESH);
    endtask

    task automatic t_isolation();
        wb(6'd6, mk_sig(32'hDDDD_0004, 4));
        fetch("R10 neighbour kept", 6'd5, mk_sig(32'hC0DE_0003, 3), S_FRESH);
        fetch("R10 untouched line", 6'd7, mk_sig(32'hDDDD_0004, 4), S_NONE);
        fetch("R10 written line", 6'd6, mk_sig(32'hDDDD_0004, 4), S_FRESH);
    endtask

    task automatic t_write_first();
        step(1'b1, 6'd9, mk_sig(32'hEEEE_0005, 1), 1'b1, 6'd9, mk_sig(32'hEEEE_0005, 2), 1'b0);
        check("R7 same tag", rsp_status, S_FRESH);
        wb(6'd10, mk_sig(32'h1111_0006, 1));
        step(1'b1, 6'd10, mk_sig(32'h1111_0006, 1), 1'b1, 6'd10, mk_sig(32'h2222_0007, 1), 1'b0);
        check("R7 old tag vs new", rsp_status, S_RPLY);
        fetch("R7 new tag kept", 6'd10, mk_sig(32'h2222_0007, 1), S_FRESH);
    endtask

    task automatic t_clear();
        wb(6'd11, mk_sig(32'h3333_0008, 1));
        step(1'b1, 6'd11, mk_sig(32'h3333_0008, 1), 1'b1, 6'd12, mk_sig(32'h4444_0009, 1), 1'b1);
        check("R9 fetch during clear", rsp_status, S_NONE);
        fetch("R9 dropped write", 6'd12, mk_sig(32'h4444_0009, 1), S_NONE);
        fetch("R9 line11 gone", 6'd11, mk_sig(32'h3333_0008, 1), S_NONE);
        fetch("R9 line5 gone", 6'd5, mk_sig(32'hC0DE_0003, 3), S_NONE);
        wb(6'd11, mk_sig(32'h5555_000A, 1));
        fetch("R9 usable after", 6'd11, mk_sig(32'h5555_000A, 1), S_FRESH);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_and_match();
        t_latency();
        t_replace();
        t_isolation();
        t_write_first();
        t_clear();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule